// File: doc/BRIEF.md
# Power-mode clock configuration selector

This block keeps three clock configurations, one for each power mode a chip can be running in: normal run, very-low-power run and high-speed run. Each configuration names a system clock source and gives two divide ratios, one for the slow clock and one for the core clock. A two-bit power-mode input chooses which configuration is in charge. That configuration is copied into a read-only status register, and the status register drives the clock control outputs.

Software writes the three configurations through a simple word-wide register port. A write that asks for a source the mode is not allowed to use leaves the stored source code unchanged. The two divide fields of that write still take effect. A per-source valid flag vector gates the status register. A mode change or a rewrite of the active configuration reaches the outputs only once the requested source reports a valid clock. Until then the clocks keep running from the last good configuration.

Top module: `pcfg_mode_clk_sel`

## Requirements
- R1: After reset the active outputs are source code 3 with both divide codes 0. The run configuration reads 0x03000000, the very-low-power configuration reads 0x02000000 and the high-speed configuration reads 0x03000000.
- R2: A write to a configuration register (run at 0x14, very-low-power at 0x18, high-speed at 0x1C) stores the slow divide code from bits 3:0, the core divide code from bits 19:16 and the source code from bits 27:24. Reading the register back returns these three fields, and every other bit reads 0. A divide code n stands for division by n+1.
- R3: In the run and high-speed configurations the legal source codes are 1 (external oscillator), 2 (slow internal RC), 3 (fast internal RC) and 6 (PLL). A write with any other source code keeps the stored source and still updates both divide codes.
- R4: In the very-low-power configuration only source codes 1 and 2 are legal. A write with any other source code keeps the stored source and still updates both divide codes.
- R5: Power mode 0 selects the run configuration, 1 selects very-low-power, 2 selects high-speed, and the reserved value 3 selects run. After a mode change the outputs show the newly selected configuration one clock later.
- R6: On each clock the status register loads the selected configuration only if src_valid[source code of that configuration] is 1. Otherwise the status register and the outputs hold their previous values, and they update on the first clock after that flag rises.
- R7: The status register at offset 0x10 reads the active fields in the same bit positions as R2. Writes to 0x10 have no effect.
- R8: A read of any offset other than 0x10, 0x14, 0x18 and 0x1C returns 0, and a write to such an offset changes nothing.
- R9: A write to the configuration that is currently selected reaches the outputs one clock after the write edge, as long as its source is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe; the write is taken on the rising clock edge |
| bus_addr | input | 12 | Byte offset for both read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, a combinational function of bus_addr |
| power_mode | input | 2 | 0 run, 1 very-low-power, 2 high-speed, 3 treated as run |
| src_valid | input | 16 | Bit k is 1 when the clock of source code k is valid |
| act_src | output | 4 | Active system clock source code |
| act_slow_div | output | 4 | Active slow divide code (divide by value+1) |
| act_core_div | output | 4 | Active core divide code (divide by value+1) |

## Verification
The bench aims at the following corner cases, and each one catches a specific fault:
- Illegal source codes 0, 4, 5, 7 to 15 go to every slot. A design that checked legality for the whole word would also drop the divide codes. A design that checked against the wrong set would let code 3 or 6 into the very-low-power slot.
- The valid flag of the requested source is held low across a mode change and across a write to the active slot. A design that did not gate the status register would switch the outputs to a clock that is not yet running. A design that gated on the old source would switch at the wrong time.
- Mode 3, writes to the status offset and reads of unmapped offsets are exercised directly. A faulty design would show up here as the wrong slot selected, a writable status register or non-zero read data.
- A long seeded random run mixes all of these with a cycle-accurate model.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;
   parameter int unsigned DATA_W   = 32;
   parameter int unsigned DIV_W    = 4;
   parameter int unsigned SRC_W    = 4;
   parameter int unsigned SLOW_LSB = 0;
   parameter int unsigned CORE_LSB = 16;
   parameter int unsigned SRC_LSB  = 24;
   parameter int unsigned NUM_MODES = 3;
   localparam int unsigned NUM_SRC = 1 << SRC_W;

   localparam int unsigned SLOT_RUN = 0;
   localparam int unsigned SLOT_VLP = 1;
   localparam int unsigned SLOT_HS  = 2;

   localparam logic [SRC_W-1:0] SRC_XOSC = 4'd1;
   localparam logic [SRC_W-1:0] SRC_SIRC = 4'd2;
   localparam logic [SRC_W-1:0] SRC_FIRC = 4'd3;
   localparam logic [SRC_W-1:0] SRC_PLL  = 4'd6;

   typedef struct packed {
      logic [SRC_W-1:0] src;
      logic [DIV_W-1:0] core;
      logic [DIV_W-1:0] slow;
   } clk_cfg_t;

   function automatic logic src_legal(input logic low_power, input logic [SRC_W-1:0] s);
      if (low_power) return (s == SRC_XOSC) || (s == SRC_SIRC);
      return (s == SRC_XOSC) || (s == SRC_SIRC) || (s == SRC_FIRC) || (s == SRC_PLL);
   endfunction

   function automatic logic [DATA_W-1:0] pack_cfg(input clk_cfg_t c);
      logic [DATA_W-1:0] w;
      w = '0;
      w[SLOW_LSB +: DIV_W] = c.slow;
      w[CORE_LSB +: DIV_W] = c.core;
      w[SRC_LSB  +: SRC_W] = c.src;
      return w;
   endfunction

   function automatic clk_cfg_t unpack_cfg(input logic [DATA_W-1:0] w);
      clk_cfg_t c;
      c.slow = w[SLOW_LSB +: DIV_W];
      c.core = w[CORE_LSB +: DIV_W];
      c.src  = w[SRC_LSB  +: SRC_W];
      return c;
   endfunction

   function automatic logic [1:0] mode_to_slot(input logic [1:0] mode);
      case (mode)
         2'd1:    return 2'(SLOT_VLP);
         2'd2:    return 2'(SLOT_HS);
         default: return 2'(SLOT_RUN);
      endcase
   endfunction
endpackage

// File: rtl/pcfg_slot.sv
module pcfg_slot
   import pcfg_pkg::*;
#(
   parameter bit               LOW_POWER = 1'b0,
   parameter logic [SRC_W-1:0] RESET_SRC = SRC_FIRC
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hit,
   input  logic [DATA_W-1:0] wdata,
   output clk_cfg_t          cfg_q
);
   if (!src_legal(LOW_POWER, RESET_SRC)) begin : g_bad_reset_src
      $error("pcfg_slot: reset source code is not legal for this slot");
   end

   clk_cfg_t wr_cfg;
   logic     unused_wbits;
   assign wr_cfg       = unpack_cfg(wdata);
   assign unused_wbits = ^wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q.src  <= RESET_SRC;
         cfg_q.core <= '0;
         cfg_q.slow <= '0;
      end else if (wr_hit) begin
         cfg_q.slow <= wr_cfg.slow;
         cfg_q.core <= wr_cfg.core;
         if (src_legal(LOW_POWER, wr_cfg.src)) cfg_q.src <= wr_cfg.src;
      end
   end
endmodule

// File: rtl/pcfg_status.sv
module pcfg_status
   import pcfg_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         power_mode,
   input  clk_cfg_t           cfgs [NUM_MODES],
   input  logic [NUM_SRC-1:0] src_valid,
   output clk_cfg_t           status_q
);
   logic [1:0] sel;
   clk_cfg_t   want;
   logic       want_ok;

   assign sel     = mode_to_slot(power_mode);
   assign want    = cfgs[sel];
   assign want_ok = src_valid[want.src];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q.src  <= SRC_FIRC;
         status_q.core <= '0;
         status_q.slow <= '0;
      end else if (want_ok) begin
         status_q <= want;
      end
   end
endmodule

// File: rtl/pcfg_mode_clk_sel.sv
module pcfg_mode_clk_sel
   import pcfg_pkg::*;
#(
   parameter int unsigned        ADDR_W   = 12,
   parameter logic [ADDR_W-1:0]  OFS_STAT = 12'h010,
   parameter logic [ADDR_W-1:0]  OFS_RUN  = 12'h014,
   parameter logic [ADDR_W-1:0]  OFS_VLP  = 12'h018,
   parameter logic [ADDR_W-1:0]  OFS_HS   = 12'h01C
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   input  logic [1:0]         power_mode,
   input  logic [15:0]        src_valid,
   output logic [3:0]         act_src,
   output logic [3:0]         act_slow_div,
   output logic [3:0]         act_core_div
);
   localparam logic [ADDR_W-1:0] SLOT_OFS [NUM_MODES] = '{OFS_RUN, OFS_VLP, OFS_HS};

   if (DATA_W != 32 || NUM_SRC != 16 || SRC_W != 4 || DIV_W != 4) begin : g_bad_widths
      $error("pcfg_mode_clk_sel: package widths do not match the port widths");
   end
   if (SRC_LSB + SRC_W > DATA_W || CORE_LSB + DIV_W > SRC_LSB) begin : g_bad_fields
      $error("pcfg_mode_clk_sel: field layout overflows the data word");
   end
   if (OFS_STAT == OFS_RUN || OFS_STAT == OFS_VLP || OFS_STAT == OFS_HS ||
       OFS_RUN == OFS_VLP || OFS_RUN == OFS_HS || OFS_VLP == OFS_HS) begin : g_bad_ofs
      $error("pcfg_mode_clk_sel: register offsets must be distinct");
   end

   clk_cfg_t cfg_q [NUM_MODES];
   clk_cfg_t status_q;
   logic [SRC_W-1:0] vlp_src_w;

   for (genvar m = 0; m < NUM_MODES; m++) begin : g_slot
      localparam bit LP = (m == SLOT_VLP);
      pcfg_slot #(
         .LOW_POWER (LP),
         .RESET_SRC (LP ? SRC_SIRC : SRC_FIRC)
      ) i_slot (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_hit (bus_wr && (bus_addr == SLOT_OFS[m])),
         .wdata  (bus_wdata),
         .cfg_q  (cfg_q[m])
      );
   end

   pcfg_status i_status (
      .clk        (clk),
      .rst_n      (rst_n),
      .power_mode (power_mode),
      .cfgs       (cfg_q),
      .src_valid  (src_valid),
      .status_q   (status_q)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == OFS_STAT) bus_rdata = pack_cfg(status_q);
      for (int m = 0; m < NUM_MODES; m++) begin
         if (bus_addr == SLOT_OFS[m]) bus_rdata = pack_cfg(cfg_q[m]);
      end
   end

   assign vlp_src_w    = cfg_q[SLOT_VLP].src;
   assign act_src      = status_q.src;
   assign act_slow_div = status_q.slow;
   assign act_core_div = status_q.core;
endmodule

// File: rtl/pcfg_mode_clk_sel_chk.sv
module pcfg_mode_clk_sel_chk
   import pcfg_pkg::*;
#(
   parameter int unsigned        ADDR_W   = 12,
   parameter logic [ADDR_W-1:0]  OFS_STAT = 12'h010,
   parameter logic [ADDR_W-1:0]  OFS_RUN  = 12'h014,
   parameter logic [ADDR_W-1:0]  OFS_VLP  = 12'h018,
   parameter logic [ADDR_W-1:0]  OFS_HS   = 12'h01C
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_rdata,
   input logic [15:0]       src_valid,
   input logic [3:0]        act_src,
   input logic [3:0]        act_slow_div,
   input logic [3:0]        act_core_div,
   input logic [3:0]        vlp_src
);
   logic [15:0] valid_d;
   logic [11:0] act_w;
   clk_cfg_t    act_cfg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid_d <= '0;
      else        valid_d <= src_valid;
   end
   assign act_w   = {act_src, act_core_div, act_slow_div};
   assign act_cfg = '{src: act_src, core: act_core_div, slow: act_slow_div};

   // R1: first cycle after reset release shows the run reset values
   p_reset_value_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (act_w == 12'h300));

   // R3: the active source is always one of the legal codes
   p_active_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (act_src == 4'd1) || (act_src == 4'd2) || (act_src == 4'd3) || (act_src == 4'd6));

   // R4: the very-low-power slot never holds a code other than 1 or 2
   p_vlp_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (vlp_src == 4'd1) || (vlp_src == 4'd2));

   // R6: the outputs change only toward a source that was valid one clock before
   p_gated_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (act_w != $past(act_w)) |-> valid_d[act_src]);

   // R7: the status offset reads the active fields
   p_status_mirror_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == OFS_STAT) |-> (bus_rdata == pack_cfg(act_cfg)));

   // R8: unmapped offsets read zero
   p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr != OFS_STAT && bus_addr != OFS_RUN && bus_addr != OFS_VLP && bus_addr != OFS_HS)
      |-> (bus_rdata == 32'h0));
endmodule

bind pcfg_mode_clk_sel pcfg_mode_clk_sel_chk #(
   .ADDR_W   (ADDR_W),
   .OFS_STAT (OFS_STAT),
   .OFS_RUN  (OFS_RUN),
   .OFS_VLP  (OFS_VLP),
   .OFS_HS   (OFS_HS)
) i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_addr     (bus_addr),
   .bus_rdata    (bus_rdata),
   .src_valid    (src_valid),
   .act_src      (act_src),
   .act_slow_div (act_slow_div),
   .act_core_div (act_core_div),
   .vlp_src      (vlp_src_w)
);

// File: tb/test_pcfg_mode_clk_sel.sv
`timescale 1ns/1ps
module test_pcfg_mode_clk_sel;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [1:0]  power_mode = '0;
   logic [15:0] src_valid = '1;
   logic [3:0]  act_src, act_slow_div, act_core_div;

   int checks = 0;
   int errors = 0;

   // model state: index 0 run, 1 very-low-power, 2 high-speed
   int m_src [3];
   int m_core[3];
   int m_slow[3];
   int s_src, s_core, s_slow;

   always #5 clk = ~clk;

   pcfg_mode_clk_sel i_pcfg_mode_clk_sel (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .power_mode(power_mode),
      .src_valid(src_valid), .act_src(act_src), .act_slow_div(act_slow_div),
      .act_core_div(act_core_div)
   );

   function automatic bit legal(input int slot, input int s);
      if (slot == 1) return (s == 1) || (s == 2);
      return (s == 1) || (s == 2) || (s == 3) || (s == 6);
   endfunction

   function automatic int slot_of_mode(input int md);
      return (md == 1) ? 1 : (md == 2) ? 2 : 0;
   endfunction

   function automatic int slot_of_addr(input logic [11:0] a);
      case (a)
         12'h014: return 0;
         12'h018: return 1;
         12'h01C: return 2;
         default: return -1;
      endcase
   endfunction

   function automatic logic [31:0] word(input int s, input int c, input int d);
      return (32'(s) << 24) | (32'(c) << 16) | 32'(d);
   endfunction

   function automatic logic [31:0] model_read(input logic [11:0] a);
      int k;
      if (a == 12'h010) return word(s_src, s_core, s_slow);
      k = slot_of_addr(a);
      if (k < 0) return 32'h0;
      return word(m_src[k], m_core[k], m_slow[k]);
   endfunction

   task automatic model_reset();
      for (int k = 0; k < 3; k++) begin
         m_src[k] = (k == 1) ? 2 : 3; m_core[k] = 0; m_slow[k] = 0;
      end
      s_src = 3; s_core = 0; s_slow = 0;
   endtask

   task automatic model_edge();
      int k, ns;
      k = slot_of_mode(int'(power_mode));
      if (src_valid[m_src[k]]) begin
         s_src = m_src[k]; s_core = m_core[k]; s_slow = m_slow[k];
      end
      if (bus_wr) begin
         k = slot_of_addr(bus_addr);
         if (k >= 0) begin
            m_slow[k] = int'(bus_wdata[3:0]);
            m_core[k] = int'(bus_wdata[19:16]);
            ns = int'(bus_wdata[27:24]);
            if (legal(k, ns)) m_src[k] = ns;
         end
      end
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   // one clock with the given inputs; returns at the following falling edge
   task automatic step(input logic wr, input logic [11:0] a, input logic [31:0] d,
                       input logic [1:0] md, input logic [15:0] v);
      bus_wr = wr; bus_addr = a; bus_wdata = d; power_mode = md; src_valid = v;
      @(posedge clk);
      model_edge();
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic chk_out(input string tag);
      chk(tag, {20'h0, act_src, act_core_div, act_slow_div}, {20'h0, 4'(s_src), 4'(s_core), 4'(s_slow)});
   endtask

   task automatic chk_rd(input string tag, input logic [11:0] a);
      logic [31:0] d;
      rd(a, d);
      chk(tag, d, model_read(a));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] d;
      logic [15:0] all_v;
      all_v = 16'hFFFF;
      void'($urandom(32'h1234_5EED));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset values
      chk("R1 outputs", {20'h0, act_src, act_core_div, act_slow_div}, 32'h300);
      rd(12'h014, d); chk("R1 run slot", d, 32'h0300_0000);
      rd(12'h018, d); chk("R1 vlp slot", d, 32'h0200_0000);
      rd(12'h01C, d); chk("R1 hs slot", d, 32'h0300_0000);

      // R2 field placement, stray bits dropped; R9 active slot reaches outputs
      step(1'b1, 12'h014, 32'hF6F5_F0FA, 2'd0, all_v);
      rd(12'h014, d); chk("R2 run readback", d, 32'h0605_000A);
      chk("R9 status not yet", {20'h0, act_src, act_core_div, act_slow_div}, 32'h300);
      step(1'b0, 12'h000, 32'h0, 2'd0, all_v);
      chk("R9 active write seen", {20'h0, act_src, act_core_div, act_slow_div}, 32'h65A);

      // R3 illegal source kept, divides taken
      step(1'b1, 12'h014, 32'h0502_0001, 2'd0, all_v);
      rd(12'h014, d); chk("R3 run illegal 5", d, 32'h0602_0001);
      step(1'b1, 12'h01C, 32'h0003_0004, 2'd0, all_v);
      rd(12'h01C, d); chk("R3 hs illegal 0", d, 32'h0303_0004);

      // R4 very-low-power legality
      step(1'b1, 12'h018, 32'h0307_0002, 2'd0, all_v);
      rd(12'h018, d); chk("R4 vlp rejects 3", d, 32'h0207_0002);
      step(1'b1, 12'h018, 32'h0604_0003, 2'd0, all_v);
      rd(12'h018, d); chk("R4 vlp rejects 6", d, 32'h0204_0003);
      step(1'b1, 12'h018, 32'h0109_0005, 2'd0, all_v);
      rd(12'h018, d); chk("R4 vlp accepts 1", d, 32'h0109_0005);

      // R5 mode selection including reserved value
      step(1'b0, 12'h000, 32'h0, 2'd1, all_v);
      chk("R5 vlp selected", {20'h0, act_src, act_core_div, act_slow_div}, 32'h195);
      step(1'b0, 12'h000, 32'h0, 2'd2, all_v);
      chk("R5 hs selected", {20'h0, act_src, act_core_div, act_slow_div}, 32'h334);
      step(1'b0, 12'h000, 32'h0, 2'd3, all_v);
      chk("R5 mode 3 is run", {20'h0, act_src, act_core_div, act_slow_div}, 32'h621);

      // R6 gating on the requested source (run slot uses PLL code 6)
      step(1'b0, 12'h000, 32'h0, 2'd1, all_v);
      step(1'b0, 12'h000, 32'h0, 2'd0, 16'hFFBF);
      chk("R6 hold while pll invalid", {20'h0, act_src, act_core_div, act_slow_div}, 32'h195);
      step(1'b1, 12'h018, 32'h010E_000C, 2'd1, 16'hFFFD);
      step(1'b0, 12'h000, 32'h0, 2'd1, 16'hFFFD);
      chk("R6 hold while osc invalid", {20'h0, act_src, act_core_div, act_slow_div}, 32'h195);
      step(1'b0, 12'h000, 32'h0, 2'd1, all_v);
      chk("R6 update after valid rises", {20'h0, act_src, act_core_div, act_slow_div}, 32'h1EC);

      // R7 status mirror and read-only
      rd(12'h010, d); chk("R7 status read", d, 32'h010E_000C);
      step(1'b1, 12'h010, 32'h0606_0606, 2'd1, all_v);
      step(1'b0, 12'h000, 32'h0, 2'd1, all_v);
      rd(12'h010, d); chk("R7 status write ignored", d, 32'h010E_000C);

      // R8 unmapped offsets
      rd(12'h000, d); chk("R8 offset 0", d, 32'h0);
      rd(12'h011, d); chk("R8 offset 0x11", d, 32'h0);
      rd(12'h020, d); chk("R8 offset 0x20", d, 32'h0);
      step(1'b1, 12'h024, 32'h0203_0405, 2'd1, all_v);
      chk_rd("R8 write to 0x24 no effect run", 12'h014);
      chk_rd("R8 write to 0x24 no effect vlp", 12'h018);
      chk_rd("R8 write to 0x24 no effect hs", 12'h01C);

      // random phase against the model (R2 R3 R4 R5 R6 R7 R8 R9)
      for (int i = 0; i < 3000; i++) begin
         logic [11:0] a;
         logic [31:0] w;
         logic [15:0] v;
         int pick;
         pick = int'($urandom % 6);
         case (pick)
            0: a = 12'h010;
            1: a = 12'h014;
            2: a = 12'h018;
            3: a = 12'h01C;
            default: a = 12'($urandom % 64);
         endcase
         w = $urandom;
         v = ($urandom % 3 == 0) ? 16'($urandom) : 16'hFFFF;
         step(($urandom % 2) == 1, a, w, 2'($urandom % 4), v);
         chk_out("R6 random outputs");
         chk_rd("R2 random read", 12'(($urandom % 2) ? (12'h010 + 12'(4 * ($urandom % 4))) : 12'($urandom % 64)));
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule